// File: doc/BRIEF.md
# DAC Control Register File

This block is the register bank of a single-channel digital-to-analog converter. Register accesses arrive on a plain parallel port: one 4-bit address shared by reads and writes, a write strobe with 16-bit write data, and a read strobe. Read data appears on the clock after the read strobe. The serial front end that produces these strobes sits outside the block, and so does the analog converter. The block holds the update-mode, power-down, reference and gain settings, and drives them out to the analog side.

Every data write first lands in a buffered code. In immediate mode the buffered code also goes straight to the active code that feeds the converter. In synchronized mode the active code changes only when a load trigger is written. The `RES_BITS` parameter sets the resolution to 16, 14 or 12 bits, and the low bits below that resolution are held at zero. The `MID_RESET` parameter sets the power-on code to midscale (8000h) or to zero.

A reference-alarm input from an analog comparator forces the code sent to the converter to zero while it is high. It leaves every stored code untouched. A keyed software reset returns all settings and codes to their defaults.

Top module: `dac_regbank`

## Requirements
- R1: The identification register at address 1h reads {0, res[2:0], 4'h1, mid, 7'h15}. Here res is 000b for 16-bit, 001b for 14-bit and 010b for 12-bit, and mid is 1 for a midscale power-on code. Reads of addresses 0h, 5h, 6h and 9h–Fh return 0000h.
- R2: After reset the gain register (4h) reads 0001h. The mode (2h), configuration (3h) and status (7h) registers read 0000h. The data register (8h) reads 8000h with a midscale power-on code and 0000h otherwise.
- R3: When mode bit 0 is 0, a write to address 8h changes `dac_code` on the clock edge that samples the write.
- R4: When mode bit 0 is 1, a data write leaves `dac_code` unchanged. A later write to address 5h with bit 4 set copies the buffered code to `dac_code`.
- R5: A load trigger (5h, bit 4) written while mode bit 0 is 0 has no effect on `dac_code`. Address 5h always reads 0000h.
- R6: A write to 5h whose bits 3:0 equal 1010b resets every register to its default on the next edge. The reset takes precedence over bit 4 of the same write. Any other value in bits 3:0 causes no reset.
- R7: Bits below the configured resolution are forced to zero, both in the data readback and in `dac_code`. At 14 bits these are bits 1:0; at 12 bits, bits 3:0.
- R8: While `ref_alarm` is high, `dac_code` is 0000h and `out_zero` is 1, and status bit 0 reads 1. The buffered and active codes are kept, and the output returns to the active code when the alarm clears.
- R9: Configuration bit 0 drives `dac_pd` and bit 8 drives `ref_pd`. Gain bit 0 drives `gain_x2` and bit 8 drives `ref_div2`. Each reads back at the same position.
- R10: Writes to addresses 0h, 1h, 6h and 7h change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | 4 | Register address for reads and writes |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 16 | Read data, valid the cycle after `rd_en` |
| ref_alarm | input | 1 | Reference-alarm flag from an analog comparator |
| dac_code | output | 16 | Code applied to the converter, MSB-aligned |
| out_zero | output | 1 | Output forced to zero by the alarm |
| dac_pd | output | 1 | Converter power-down request |
| ref_pd | output | 1 | Internal reference disable |
| ref_div2 | output | 1 | Reference divide-by-two select |
| gain_x2 | output | 1 | Output buffer gain-of-two select |

## Verification
A corrupted active code shows on `dac_code` on the very edge that should have updated it. When the buffered code is wrong, the fault stays hidden in synchronized mode until the next load trigger, or until the data register is read back a cycle later. A wrong mode bit therefore surfaces only through the next data write or trigger. For this reason the stimulus alternates modes and reads back after each operation. A missed or false software reset shows up at once on `gain_x2`, the other control pins and `dac_code`.

// File: rtl/dac_regbank_pkg.sv
package dac_regbank_pkg;
  localparam logic [3:0] A_NOP  = 4'h0;
  localparam logic [3:0] A_ID   = 4'h1;
  localparam logic [3:0] A_MODE = 4'h2;
  localparam logic [3:0] A_CFG  = 4'h3;
  localparam logic [3:0] A_GAIN = 4'h4;
  localparam logic [3:0] A_TRIG = 4'h5;
  localparam logic [3:0] A_STAT = 4'h7;
  localparam logic [3:0] A_DATA = 4'h8;
  localparam logic [3:0] RST_KEY = 4'b1010;
  localparam int TRIG_LOAD_BIT = 4;

  function automatic logic [15:0] id_word(input int res_bits, input bit mid);
    logic [2:0] rc;
    rc = 3'((16 - res_bits) / 2);
    return {1'b0, rc, 4'h1, mid, 7'h15};
  endfunction
endpackage

// File: rtl/dac_ctrl_regs.sv
module dac_ctrl_regs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        soft_rst,
  input  logic        wr_mode,
  input  logic        wr_cfg,
  input  logic        wr_gain,
  input  logic [15:0] wr_data,
  output logic        sync_en,
  output logic        dac_pd,
  output logic        ref_pd,
  output logic        ref_div2,
  output logic        gain_x2
);
  logic sync_d, pd_d, rpd_d, div_d, gx2_d;

  always_comb begin
    sync_d = sync_en;
    pd_d   = dac_pd;
    rpd_d  = ref_pd;
    div_d  = ref_div2;
    gx2_d  = gain_x2;
    if (soft_rst) begin
      sync_d = 1'b0;
      pd_d   = 1'b0;
      rpd_d  = 1'b0;
      div_d  = 1'b0;
      gx2_d  = 1'b1;
    end else begin
      if (wr_mode) sync_d = wr_data[0];
      if (wr_cfg) begin
        pd_d  = wr_data[0];
        rpd_d = wr_data[8];
      end
      if (wr_gain) begin
        gx2_d = wr_data[0];
        div_d = wr_data[8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_en  <= 1'b0;
      dac_pd   <= 1'b0;
      ref_pd   <= 1'b0;
      ref_div2 <= 1'b0;
      gain_x2  <= 1'b1;
    end else begin
      sync_en  <= sync_d;
      dac_pd   <= pd_d;
      ref_pd   <= rpd_d;
      ref_div2 <= div_d;
      gain_x2  <= gx2_d;
    end
  end
endmodule

// File: rtl/dac_code_regs.sv
module dac_code_regs #(
  parameter int RES_BITS  = 16,
  parameter bit MID_RESET = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        soft_rst,
  input  logic        wr_code,
  input  logic        load,
  input  logic        sync_en,
  input  logic [15:0] wr_data,
  output logic [15:0] buf_code,
  output logic [15:0] act_code
);
  localparam int PAD = 16 - RES_BITS;
  localparam logic [15:0] POR_CODE = MID_RESET ? 16'h8000 : 16'h0000;

  logic [15:0] trimmed;
  logic [15:0] buf_d, act_d;
  logic        buf_ce, act_ce;

  generate
    if (PAD == 0) begin : g_full
      assign trimmed = wr_data;
    end else begin : g_trim
      assign trimmed = {wr_data[15:PAD], {PAD{1'b0}}};
    end
  endgenerate

  always_comb begin
    buf_ce = soft_rst | wr_code;
    act_ce = soft_rst | (wr_code & ~sync_en) | (load & sync_en);
    buf_d  = soft_rst ? POR_CODE : trimmed;
    if (soft_rst)       act_d = POR_CODE;
    else if (wr_code)   act_d = trimmed;
    else                act_d = buf_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_code <= POR_CODE;
      act_code <= POR_CODE;
    end else begin
      if (buf_ce) buf_code <= buf_d;
      if (act_ce) act_code <= act_d;
    end
  end
endmodule

// File: rtl/dac_read_mux.sv
module dac_read_mux
  import dac_regbank_pkg::*;
#(
  parameter int RES_BITS  = 16,
  parameter bit MID_RESET = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_en,
  input  logic [3:0]  addr,
  input  logic        sync_en,
  input  logic        dac_pd,
  input  logic        ref_pd,
  input  logic        ref_div2,
  input  logic        gain_x2,
  input  logic        alarm,
  input  logic [15:0] buf_code,
  output logic [15:0] rd_data
);
  localparam logic [15:0] ID_WORD = id_word(RES_BITS, MID_RESET);
  logic [15:0] sel;

  always_comb begin
    case (addr)
      A_ID:    sel = ID_WORD;
      A_MODE:  sel = {15'd0, sync_en};
      A_CFG:   sel = {7'd0, ref_pd, 7'd0, dac_pd};
      A_GAIN:  sel = {7'd0, ref_div2, 7'd0, gain_x2};
      A_STAT:  sel = {15'd0, alarm};
      A_DATA:  sel = buf_code;
      default: sel = 16'h0000;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= 16'h0000;
    else if (rd_en) rd_data <= sel;
  end
endmodule

// File: rtl/dac_regbank.sv
module dac_regbank
  import dac_regbank_pkg::*;
#(
  parameter int RES_BITS  = 16,
  parameter bit MID_RESET = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  addr,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  input  logic        rd_en,
  output logic [15:0] rd_data,
  input  logic        ref_alarm,
  output logic [15:0] dac_code,
  output logic        out_zero,
  output logic        dac_pd,
  output logic        ref_pd,
  output logic        ref_div2,
  output logic        gain_x2
);
  logic [1:0]  rst_pipe;
  logic        rst_sync_n;
  logic        sync_en, soft_rst, load;
  logic        wr_trig;
  logic [15:0] buf_code, act_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign wr_trig  = wr_en && (addr == A_TRIG);
  assign soft_rst = wr_trig && (wr_data[3:0] == RST_KEY);
  assign load     = wr_trig && wr_data[TRIG_LOAD_BIT] && !soft_rst;

  dac_ctrl_regs u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .soft_rst(soft_rst),
    .wr_mode(wr_en && (addr == A_MODE)),
    .wr_cfg(wr_en && (addr == A_CFG)),
    .wr_gain(wr_en && (addr == A_GAIN)),
    .wr_data(wr_data), .sync_en(sync_en), .dac_pd(dac_pd),
    .ref_pd(ref_pd), .ref_div2(ref_div2), .gain_x2(gain_x2)
  );

  dac_code_regs #(.RES_BITS(RES_BITS), .MID_RESET(MID_RESET)) u_code (
    .clk(clk), .rst_n(rst_sync_n), .soft_rst(soft_rst),
    .wr_code(wr_en && (addr == A_DATA)), .load(load), .sync_en(sync_en),
    .wr_data(wr_data), .buf_code(buf_code), .act_code(act_code)
  );

  dac_read_mux #(.RES_BITS(RES_BITS), .MID_RESET(MID_RESET)) u_rd (
    .clk(clk), .rst_n(rst_sync_n), .rd_en(rd_en), .addr(addr),
    .sync_en(sync_en), .dac_pd(dac_pd), .ref_pd(ref_pd),
    .ref_div2(ref_div2), .gain_x2(gain_x2), .alarm(ref_alarm),
    .buf_code(buf_code), .rd_data(rd_data)
  );

  assign out_zero = ref_alarm;
  assign dac_code = ref_alarm ? 16'h0000 : act_code;
endmodule

// File: rtl/dac_regbank_chk.sv
module dac_regbank_chk #(
  parameter int RES_BITS = 16
) (
  input logic        clk,
  input logic        rst_sync_n,
  input logic [3:0]  addr,
  input logic        wr_en,
  input logic [15:0] wr_data,
  input logic        rd_en,
  input logic [15:0] rd_data,
  input logic        ref_alarm,
  input logic [15:0] dac_code,
  input logic        sync_en,
  input logic        dac_pd,
  input logic        ref_pd,
  input logic        ref_div2,
  input logic        gain_x2,
  input logic [15:0] buf_code,
  input logic [15:0] act_code
);
  localparam logic [15:0] KEEP = 16'hFFFF << (16 - RES_BITS);

  assert_async_update_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && addr == 4'h8 && !sync_en) |=> (act_code == ($past(wr_data) & KEEP)));

  assert_sync_hold_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && addr == 4'h8 && sync_en) |=> $stable(act_code));

  assert_load_ignored_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && addr == 4'h5 && !sync_en && wr_data[3:0] != 4'hA) |=> $stable(act_code));

  assert_trig_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_en && addr == 4'h5) |=> (rd_data == 16'h0000));

  assert_soft_reset_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && addr == 4'h5 && wr_data[3:0] == 4'hA)
      |=> (gain_x2 && !dac_pd && !ref_pd && !ref_div2 && !sync_en));

  assert_low_bits_zero_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((dac_code & ~KEEP) == 16'h0000));

  assert_alarm_keeps_codes_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ref_alarm && !wr_en) |=> ($stable(act_code) && $stable(buf_code)));
endmodule

bind dac_regbank dac_regbank_chk #(.RES_BITS(RES_BITS)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .addr(addr), .wr_en(wr_en),
  .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .ref_alarm(ref_alarm),
  .dac_code(dac_code), .sync_en(sync_en), .dac_pd(dac_pd), .ref_pd(ref_pd),
  .ref_div2(ref_div2), .gain_x2(gain_x2), .buf_code(buf_code), .act_code(act_code)
);

// File: tb/tb_dac_regbank.sv
`timescale 1ns/1ps
module tb_dac_regbank;
  localparam int RES = 14;
  localparam bit MID = 1'b1;
  localparam logic [15:0] KEEP = 16'hFFFC;
  localparam logic [15:0] POR  = 16'h8000;

  logic clk = 1'b0;
  logic rst_n;
  logic [3:0] addr;
  logic wr_en, rd_en, ref_alarm;
  logic [15:0] wr_data, rd_data, dac_code;
  logic out_zero, dac_pd, ref_pd, ref_div2, gain_x2;

  always #2.5 clk = ~clk;

  dac_regbank #(.RES_BITS(RES), .MID_RESET(MID)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .ref_alarm(ref_alarm), .dac_code(dac_code),
    .out_zero(out_zero), .dac_pd(dac_pd), .ref_pd(ref_pd), .ref_div2(ref_div2),
    .gain_x2(gain_x2)
  );

  int n_vec = 0, n_bad = 0;
  bit done = 0;
  bit m_sync, m_pd, m_rpd, m_div, m_gx2;
  logic [15:0] m_buf, m_act;

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  function automatic void model_reset();
    m_sync = 0; m_pd = 0; m_rpd = 0; m_div = 0; m_gx2 = 1;
    m_buf = POR; m_act = POR;
  endfunction

  function automatic void model_write(input logic [3:0] a, input logic [15:0] d);
    case (a)
      4'h2: m_sync = d[0];
      4'h3: begin m_pd = d[0]; m_rpd = d[8]; end
      4'h4: begin m_gx2 = d[0]; m_div = d[8]; end
      4'h5: if (d[3:0] == 4'hA) model_reset();
            else if (d[4] && m_sync) m_act = m_buf;
      4'h8: begin m_buf = d & KEEP; if (!m_sync) m_act = m_buf; end
      default: ;
    endcase
  endfunction

  function automatic logic [15:0] exp_read(input logic [3:0] a);
    case (a)
      4'h1: return 16'h1195;
      4'h2: return {15'd0, m_sync};
      4'h3: return {7'd0, m_rpd, 7'd0, m_pd};
      4'h4: return {7'd0, m_div, 7'd0, m_gx2};
      4'h7: return {15'd0, ref_alarm};
      4'h8: return m_buf;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic check_pins(input string req);
    check(req, dac_code, ref_alarm ? 16'h0000 : m_act);
    check(req, {11'd0, out_zero, dac_pd, ref_pd, ref_div2, gain_x2},
               {11'd0, ref_alarm, m_pd, m_rpd, m_div, m_gx2});
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
    model_write(a, d);
  endtask

  task automatic rd_check(input string req, input logic [3:0] a);
    logic [15:0] e;
    @(negedge clk); addr = a; rd_en = 1; e = exp_read(a);
    @(negedge clk); rd_en = 0;
    check(req, rd_data, e);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    addr = 0; wr_en = 0; rd_en = 0; wr_data = 0; ref_alarm = 0;
    rst_n = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R2 reset state, R1 identification and unused addresses
    check_pins("R2");
    for (int a = 0; a < 16; a++) rd_check(a == 1 ? "R1" : "R2", 4'(a));

    // R3 immediate mode, R7 low bits trimmed
    wr(4'h8, 16'h1237); check_pins("R3"); rd_check("R7", 4'h8);
    // R5 trigger ignored in immediate mode
    wr(4'h8, 16'hABCD); wr(4'h5, 16'h0010); check_pins("R5"); rd_check("R5", 4'h5);
    // R4 synchronized mode: hold then load
    wr(4'h2, 16'h0001); wr(4'h8, 16'h4444); check_pins("R4");
    wr(4'h5, 16'h0010); check_pins("R4");
    // R6 non-key code no reset, then keyed reset wins over load
    wr(4'h4, 16'h0100); wr(4'h5, 16'h000B); check_pins("R6");
    wr(4'h8, 16'h7777); wr(4'h5, 16'h001A); check_pins("R6"); rd_check("R6", 4'h8);
    // R9 control bits
    wr(4'h3, 16'h0101); wr(4'h4, 16'h0100); check_pins("R9");
    rd_check("R9", 4'h3); rd_check("R9", 4'h4);
    // R10 writes to read-only/unused addresses
    wr(4'h0, 16'hFFFF); wr(4'h1, 16'hFFFF); wr(4'h6, 16'hFFFF); wr(4'h7, 16'hFFFF);
    check_pins("R10");
    for (int a = 1; a < 9; a++) rd_check("R10", 4'(a));
    // R8 alarm forces zero, keeps codes
    wr(4'h8, 16'h5A5B);
    @(negedge clk); ref_alarm = 1;
    @(negedge clk); check_pins("R8"); rd_check("R8", 4'h7);
    wr(4'h8, 16'h1111); check_pins("R8");
    @(negedge clk); ref_alarm = 0;
    @(negedge clk); check_pins("R8"); rd_check("R8", 4'h8); rd_check("R8", 4'h7);

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [3:0] a;
      logic [15:0] d;
      int k;
      k = int'($urandom % 16);
      a = 4'($urandom % 10);
      d = 16'($urandom);
      if (a == 4'h5 && k < 3) d[3:0] = 4'hA;
      if (k == 15) begin @(negedge clk); ref_alarm = ~ref_alarm; end
      wr(a, d);
      check_pins(a == 4'h5 ? "R6" : (a == 4'h8 ? (m_sync ? "R4" : "R3") : "R9"));
      rd_check(a == 4'h8 ? "R7" : "R10", 4'($urandom % 16));
    end
    summary();
  end
endmodule